// File: doc/BRIEF.md
# UART Receive Idle Line Detector

This block watches the synchronized receive line of a UART and raises a sticky flag once the line has stayed high for one full character time after activity. Character time is counted in bit-time ticks supplied by the baud logic; the frame-length setting selects a span of 10 to 13 bit times. The receiver tells the block when a start bit is seen and when the stop bits are done, and it pulses a strobe each time a character is stored or a break is detected.

An idle-type select picks where counting begins. With the select low, counting begins at the start bit, so high data bits and the stop bits of an all-ones character count toward the idle span. With the select high, counting begins only once the stop bits are done, and every bit of the frame is ignored. Software clears the flag by writing 1. The flag can be set once for each arming: a stored character or a detected break arms it. Reset leaves it clear and disarmed.

Top module: `uart_idle_detect`

## Requirements
- R1: After reset `idle_flag` is 0.
- R2: The idle span is 10 + `char_len` bit times (`char_len` 0..3 gives 10..13). `idle_flag` rises on the clock edge that samples the tick carrying the last consecutive high bit of that span. Clock cycles without `bit_tick` do not count.
- R3: With `idle_after_stop` = 0, a `start_seen` pulse restarts the count at zero, and high data and stop bits count toward the span.
- R4: With `idle_after_stop` = 1, ticks between `start_seen` and `stop_done` are not counted. Counting restarts from zero at `stop_done`.
- R5: A tick that samples `rx_line` low resets the count to zero.
- R6: A cycle with `idle_clr` = 1 clears `idle_flag` at the next edge. The flag holds its value while `idle_clr` is 0.
- R7: Once the flag has been set, it cannot be set again until `char_stored` or `break_det` pulses, even if a new idle span completes.
- R8: A `break_det` pulse arms the flag in the same way as `char_stored`.
- R9: The flag is set only once per idle period. A line that stays high after the flag is cleared does not set it again.
- R10: After reset the flag stays disarmed until the first `char_stored` or `break_det`.
- R11: When a set and `idle_clr` fall in the same cycle, the set wins and `idle_flag` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_line | input | 1 | Synchronized receive line |
| bit_tick | input | 1 | One-cycle pulse once per bit time, at the sample point |
| char_len | input | LEN_W | Idle span minus 10, in bit times |
| idle_after_stop | input | 1 | 0: count from the start bit; 1: count from the end of the stop bits |
| start_seen | input | 1 | Pulse: the receiver has detected a start bit |
| stop_done | input | 1 | Pulse: the receiver has finished the stop bits |
| char_stored | input | 1 | Pulse: a character was written to the receive buffer |
| break_det | input | 1 | Pulse: a break was detected |
| idle_clr | input | 1 | Write-1-to-clear strobe for the flag |
| idle_flag | output | 1 | Sticky idle-line flag |

## Verification
Each result is due exactly one clock edge after the cycle that causes it. The flag rises on the edge that samples the completing tick. A clear or an arm takes effect on the edge after its strobe. The bench drives every input on the falling edge and holds it for one full cycle. It reads `idle_flag` on the next falling edge, after that single register stage has updated. It never samples on the rising edge.

// File: rtl/uart_idle_pkg.sv
package uart_idle_pkg;
    // arming and flag state held by the flag controller
    typedef struct packed {
        logic armed;
        logic flag;
    } flag_state_t;
endpackage

// File: rtl/idle_bit_counter.sv
module idle_bit_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_line,
    input  logic             bit_tick,
    input  logic             idle_after_stop,
    input  logic             start_seen,
    input  logic             stop_done,
    input  logic [CNT_W-1:0] target,
    output logic             span_hit
);
    typedef struct packed {
        logic             en;
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic       restart;

    always_comb begin
        st_d     = st_q;
        restart  = start_seen || (stop_done && idle_after_stop);
        span_hit = 1'b0;
        if (start_seen) begin
            st_d.cnt = '0;
            st_d.en  = ~idle_after_stop;
        end else if (stop_done && idle_after_stop) begin
            st_d.cnt = '0;
            st_d.en  = 1'b1;
        end else if (bit_tick && st_q.en) begin
            if (!rx_line) begin
                st_d.cnt = '0;
            end else if (st_q.cnt < target) begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
        if (!restart && bit_tick && st_q.en && rx_line &&
            (st_q.cnt == target - CNT_W'(1))) begin
            span_hit = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/idle_flag_ctrl.sv
module idle_flag_ctrl
    import uart_idle_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic span_hit,
    input  logic rearm,
    input  logic clr,
    output logic flag,
    output logic armed
);
    flag_state_t st_d, st_q;
    logic        set_now;

    always_comb begin
        st_d    = st_q;
        set_now = span_hit && st_q.armed;
        if (set_now) st_d.armed = 1'b0;
        if (rearm)   st_d.armed = 1'b1;
        if (clr)     st_d.flag  = 1'b0;
        if (set_now) st_d.flag  = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag  = st_q.flag;
    assign armed = st_q.armed;
endmodule

// File: rtl/uart_idle_detect.sv
module uart_idle_detect #(
    parameter int BASE_BITS = 10,
    parameter int LEN_W     = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_line,
    input  logic             bit_tick,
    input  logic [LEN_W-1:0] char_len,
    input  logic             idle_after_stop,
    input  logic             start_seen,
    input  logic             stop_done,
    input  logic             char_stored,
    input  logic             break_det,
    input  logic             idle_clr,
    output logic             idle_flag
);
    localparam int MAX_BITS = BASE_BITS + (1 << LEN_W) - 1;
    localparam int CNT_W    = $clog2(MAX_BITS + 1);

    logic [CNT_W-1:0] target;
    logic             hit_w;
    logic             armed_w;

    assign target = CNT_W'(BASE_BITS) + CNT_W'(char_len);

    idle_bit_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk             (clk),
        .rst_n           (rst_n),
        .rx_line         (rx_line),
        .bit_tick        (bit_tick),
        .idle_after_stop (idle_after_stop),
        .start_seen      (start_seen),
        .stop_done       (stop_done),
        .target          (target),
        .span_hit        (hit_w)
    );

    idle_flag_ctrl u_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .span_hit (hit_w),
        .rearm    (char_stored || break_det),
        .clr      (idle_clr),
        .flag     (idle_flag),
        .armed    (armed_w)
    );
endmodule

// File: rtl/uart_idle_detect_chk.sv
module uart_idle_detect_chk (
    input logic clk,
    input logic rst_n,
    input logic rx_line,
    input logic bit_tick,
    input logic char_stored,
    input logic break_det,
    input logic idle_clr,
    input logic idle_flag,
    input logic hit_w,
    input logic armed_w
);
    AST_RISE_ON_HIGH_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(idle_flag) |-> $past(bit_tick && rx_line)); // R2
    AST_RISE_NEEDS_HIGH_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(idle_flag) |-> $past(rx_line)); // R5
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_clr && !hit_w) |=> !idle_flag); // R6
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_flag && !idle_clr) |=> idle_flag); // R6
    AST_SET_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(idle_flag) |-> (!armed_w || $past(char_stored || break_det))); // R7
    AST_RISE_ONLY_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(idle_flag) |-> $past(armed_w)); // R10
    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_clr && hit_w && armed_w) |=> idle_flag); // R11
endmodule

bind uart_idle_detect uart_idle_detect_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_line     (rx_line),
    .bit_tick    (bit_tick),
    .char_stored (char_stored),
    .break_det   (break_det),
    .idle_clr    (idle_clr),
    .idle_flag   (idle_flag),
    .hit_w       (hit_w),
    .armed_w     (armed_w)
);

// File: tb/uart_idle_detect_test.sv
module uart_idle_detect_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_line = 1'b1;
    logic       bit_tick = 1'b0;
    logic [1:0] char_len = 2'd0;
    logic       idle_after_stop = 1'b0;
    logic       start_seen = 1'b0;
    logic       stop_done = 1'b0;
    logic       char_stored = 1'b0;
    logic       break_det = 1'b0;
    logic       idle_clr = 1'b0;
    logic       idle_flag;
    int         checks = 0;
    int         failures = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    uart_idle_detect uut (
        .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .bit_tick(bit_tick),
        .char_len(char_len), .idle_after_stop(idle_after_stop),
        .start_seen(start_seen), .stop_done(stop_done),
        .char_stored(char_stored), .break_det(break_det),
        .idle_clr(idle_clr), .idle_flag(idle_flag)
    );

    typedef struct packed {
        logic       mode;
        logic [1:0] len;
        logic [4:0] highs;
        logic       expect_flag;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{1'b0, 2'd0, 5'd9,  1'b0},
        '{1'b0, 2'd0, 5'd10, 1'b1},
        '{1'b0, 2'd3, 5'd12, 1'b0},
        '{1'b0, 2'd3, 5'd13, 1'b1},
        '{1'b1, 2'd1, 5'd10, 1'b0},
        '{1'b1, 2'd1, 5'd11, 1'b1},
        '{1'b1, 2'd2, 5'd12, 1'b1},
        '{1'b0, 2'd2, 5'd11, 1'b0}
    };

    task automatic check(input logic actual, input logic expected, input string req);
        checks++;
        if (actual !== expected) begin
            failures++;
            $display("FAIL %s idle_flag actual=%0b expected=%0b", req, actual, expected);
        end
    endtask

    task automatic bits(input logic level, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_line  = level;
            bit_tick = 1'b1;
            @(negedge clk);
            bit_tick = 1'b0;
            rx_line  = 1'b1;
        end
    endtask

    task automatic pulse_start;
        @(negedge clk); start_seen = 1'b1;
        @(negedge clk); start_seen = 1'b0;
    endtask

    task automatic pulse_stop;
        @(negedge clk); stop_done = 1'b1;
        @(negedge clk); stop_done = 1'b0;
    endtask

    task automatic pulse_arm;
        @(negedge clk); char_stored = 1'b1;
        @(negedge clk); char_stored = 1'b0;
    endtask

    task automatic pulse_clr;
        @(negedge clk); idle_clr = 1'b1;
        @(negedge clk); idle_clr = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(idle_flag, 1'b0, "R1 reset");

        // R10: no arming yet, a long idle span must not set the flag
        idle_after_stop = 1'b0;
        pulse_start();
        bits(1'b0, 1);
        bits(1'b1, 15);
        check(idle_flag, 1'b0, "R10 disarmed after reset");

        // vector table: R2 span length, R3 count from start, R4 count from stop
        for (int v = 0; v < 8; v++) begin
            pulse_arm();
            pulse_clr();
            idle_after_stop = VECS[v].mode;
            char_len        = VECS[v].len;
            pulse_start();
            bits(1'b0, 1);
            if (VECS[v].mode) begin
                bits(1'b1, 9);
                pulse_stop();
            end
            bits(1'b1, int'(VECS[v].highs));
            check(idle_flag, VECS[v].expect_flag,
                  VECS[v].mode ? "R4 R2 span after stop" : "R3 R2 span from start");
        end

        // R5: a low bit restarts the count
        pulse_arm();
        pulse_clr();
        idle_after_stop = 1'b0;
        char_len = 2'd0;
        pulse_start();
        bits(1'b0, 1);
        bits(1'b1, 6);
        bits(1'b0, 1);
        bits(1'b1, 9);
        check(idle_flag, 1'b0, "R5 low bit resets count");
        // R2: clock cycles without a tick do not count
        repeat (30) @(negedge clk);
        check(idle_flag, 1'b0, "R2 no tick no count");
        bits(1'b1, 1);
        check(idle_flag, 1'b1, "R5 full span after restart");

        // R9: line stays high, flag holds; after clear it stays clear
        bits(1'b1, 20);
        check(idle_flag, 1'b1, "R6 flag holds");
        pulse_clr();
        check(idle_flag, 1'b0, "R6 write one clears");
        bits(1'b1, 20);
        check(idle_flag, 1'b0, "R9 set only once");

        // R7: new idle span without rearm does not set
        pulse_start();
        bits(1'b0, 1);
        bits(1'b1, 12);
        check(idle_flag, 1'b0, "R7 no rearm no set");

        // R8: break detection rearms
        @(negedge clk); break_det = 1'b1;
        @(negedge clk); break_det = 1'b0;
        pulse_start();
        bits(1'b0, 1);
        bits(1'b1, 10);
        check(idle_flag, 1'b1, "R8 break rearms");

        // R11: set and clear in the same cycle
        pulse_arm();
        pulse_clr();
        pulse_start();
        bits(1'b0, 1);
        bits(1'b1, 9);
        @(negedge clk);
        rx_line = 1'b1; bit_tick = 1'b1; idle_clr = 1'b1;
        @(negedge clk);
        bit_tick = 1'b0; idle_clr = 1'b0;
        check(idle_flag, 1'b1, "R11 set beats clear");

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule